// File: doc/BRIEF.md
# Directory Home Node Controller

This block is the home side of a directory coherence scheme for a small group of processor caches. For every memory block it owns, it keeps a directory entry: one presence bit per processor, an exclusive bit, and a busy flag with a mask of responses still owed. Processors send read or read-exclusive requests on per-port valid/ready channels. The controller answers with one outgoing message at a time: a shared or exclusive data grant, an invalidation, a forward command to the current owner, or a negative acknowledgement.

Ownership moves in three hops. When a block is held exclusively, home forwards the request to the owner. The owner sends its data straight to the requester and a revision message, carrying the data, back to home. Home writes that data into its block store. While a block waits for invalidation acknowledgements or a revision, it is busy, and every request that reaches it gets a NACK. The requester must retry. Requests that arrive in the same cycle are taken one at a time, lowest port index first. Block data is held in a register array that clears to zero at reset.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is uncached and not busy, every stored block is zero, `msg_valid_o` and every `req_ready_o` bit are low, and `rsp_ready_o` is high.
- R2: When several ports assert a request in one cycle, only the lowest-numbered port sees `req_ready_o` high. The others stay pending and are taken in later cycles.
- R3: A read to a block that no other cache holds returns an exclusive data grant (kind 1) to the requester with the stored data. The requester becomes the sole exclusive holder.
- R4: A read to a non-exclusive block that other caches hold returns a shared data grant (kind 0) with the stored data and adds the requester's presence bit.
- R5: A read-exclusive to a non-exclusive block sends an invalidation (kind 2) to every other present cache in ascending port order, then an exclusive grant (kind 1) to the requester. The block stays busy until each invalidated cache has responded. With no other holder, only the grant is sent.
- R6: A read-exclusive to a block exclusively held by another port sends a forward-invalidate (kind 3) to the owner, with `msg_req_o` naming the requester. The requester becomes the exclusive holder.
- R7: A read to a block exclusively held by another port sends a forward-read (kind 4) to the owner, with `msg_req_o` naming the requester. The block becomes shared by the owner and the requester.
- R8: A request to a busy block returns a NACK (kind 5) to the requester and leaves the directory entry unchanged.
- R9: A busy block returns to a stable state only when every owed response has arrived. A response from a port that owes nothing, or to a non-busy block, has no effect.
- R10: A revision response (`rsp_rev_i`=1) from an owing port writes `rsp_data_i` into the stored block, and later data grants carry that value.
- R11: A request from the port that already holds the block exclusively returns a NACK (kind 5).
- R12: At most one message is offered at a time. An offered message holds its fields stable until `msg_ready_i`. No request is accepted while any message of an earlier request is still unsent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_PROC | Request valid, one bit per port |
| req_excl_i | input | N_PROC | 1 = read-exclusive, 0 = read, per port |
| req_addr_i | input | N_PROC*ADDR_W | Block index per port, port p at bits [p*ADDR_W +: ADDR_W] |
| req_ready_o | output | N_PROC | Request accepted, one bit per port |
| rsp_valid_i | input | 1 | Cache response valid |
| rsp_rev_i | input | 1 | 1 = revision carrying data, 0 = invalidation acknowledgement |
| rsp_src_i | input | ID_W | Responding port |
| rsp_addr_i | input | ADDR_W | Block index of the response |
| rsp_data_i | input | DATA_W | Revision data |
| rsp_ready_o | output | 1 | Response accepted, always high |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_ready_i | input | 1 | Outgoing message taken |
| msg_kind_o | output | 3 | 0 shared grant, 1 exclusive grant, 2 invalidate, 3 forward-invalidate, 4 forward-read, 5 NACK |
| msg_dst_o | output | ID_W | Destination port |
| msg_req_o | output | ID_W | Port whose request caused the message |
| msg_addr_o | output | ADDR_W | Block index |
| msg_data_o | output | DATA_W | Block data for grants, zero otherwise |

## Verification
A corrupted presence mask shows up at the next request to that block. An invalidation goes to the wrong port or is missing, or a forward names the wrong owner, within the few cycles it takes to drain the message sequence. A busy flag that clears early lets a conflicting request through where a NACK was due. One that never clears turns every later request to that block into a NACK. A lost revision write shows as stale data in the next grant. The scoreboard catches each of these on the first message that differs.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    MSG_DATA_SHR  = 3'd0,
    MSG_DATA_EXCL = 3'd1,
    MSG_INV       = 3'd2,
    MSG_FWD_INV   = 3'd3,
    MSG_FWD_RD    = 3'd4,
    MSG_NACK      = 3'd5
  } msg_kind_e;
endpackage

// File: rtl/dir_prio_arb.sv
module dir_prio_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en_i && req_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        any_o    = 1'b1;
      end
    end
  end

  p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_lowest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> ((req_i & (gnt_o - N'(1))) == '0));
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          busy_i,
  input  logic          excl_i,
  input  logic [N-1:0]  pres_i,
  input  logic [IW-1:0] req_id_i,
  input  logic          rdx_i,
  output logic          we_o,
  output logic          nbusy_o,
  output logic          nexcl_o,
  output logic [N-1:0]  npres_o,
  output logic [N-1:0]  npend_o,
  output msg_kind_e     kind_o,
  output logic [IW-1:0] dst_o,
  output logic [N-1:0]  inv_o
);
  logic [N-1:0]  req_oh;
  logic [N-1:0]  others;
  logic [IW-1:0] owner;

  always_comb begin
    req_oh = '0;
    req_oh[req_id_i] = 1'b1;
    others = pres_i & ~req_oh;
    owner  = '0;
    for (int i = 0; i < N; i++) if (pres_i[i]) owner = IW'(i);

    we_o    = 1'b0;
    nbusy_o = 1'b0;
    nexcl_o = 1'b0;
    npres_o = pres_i;
    npend_o = '0;
    kind_o  = MSG_NACK;
    dst_o   = req_id_i;
    inv_o   = '0;

    if (busy_i || (excl_i && pres_i[req_id_i])) begin
      // conflict or request from the holder itself: NACK, entry untouched
    end else if (excl_i) begin
      we_o    = 1'b1;
      nbusy_o = 1'b1;
      npend_o = pres_i;
      dst_o   = owner;
      if (rdx_i) begin
        kind_o  = MSG_FWD_INV;
        nexcl_o = 1'b1;
        npres_o = req_oh;
      end else begin
        kind_o  = MSG_FWD_RD;
        npres_o = pres_i | req_oh;
      end
    end else if (rdx_i) begin
      we_o    = 1'b1;
      kind_o  = MSG_DATA_EXCL;
      nexcl_o = 1'b1;
      npres_o = req_oh;
      inv_o   = others;
      npend_o = others;
      nbusy_o = |others;
    end else if (others == '0) begin
      we_o    = 1'b1;
      kind_o  = MSG_DATA_EXCL;
      nexcl_o = 1'b1;
      npres_o = req_oh;
    end else begin
      we_o    = 1'b1;
      kind_o  = MSG_DATA_SHR;
      npres_o = pres_i | req_oh;
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store #(
  parameter int N      = 4,
  parameter int NE     = 16,
  parameter int DW     = 32,
  parameter int AW     = (NE > 1) ? $clog2(NE) : 1,
  parameter int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_busy_o,
  output logic          rd_excl_o,
  output logic [N-1:0]  rd_pres_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_busy_i,
  input  logic          wr_excl_i,
  input  logic [N-1:0]  wr_pres_i,
  input  logic [N-1:0]  wr_pend_i,
  input  logic          rsp_en_i,
  input  logic [AW-1:0] rsp_addr_i,
  input  logic [IW-1:0] rsp_src_i,
  input  logic          rsp_rev_i,
  input  logic [DW-1:0] rsp_data_i
);
  logic          busy_q [NE];
  logic          excl_q [NE];
  logic [N-1:0]  pres_q [NE];
  logic [N-1:0]  pend_q [NE];
  logic [DW-1:0] mem_q  [NE];
  logic [N-1:0]  src_oh;

  always_comb begin
    src_oh = '0;
    src_oh[rsp_src_i] = 1'b1;
  end

  assign rd_busy_o = busy_q[rd_addr_i];
  assign rd_excl_o = excl_q[rd_addr_i];
  assign rd_pres_o = pres_q[rd_addr_i];
  assign rd_data_o = mem_q[rd_addr_i];

  for (genvar e = 0; e < NE; e++) begin : g_ent
    logic wr_hit;
    logic rsp_hit;
    logic [N-1:0] pend_left;
    assign wr_hit    = wr_en_i && (wr_addr_i == AW'(e));
    assign rsp_hit   = rsp_en_i && (rsp_addr_i == AW'(e)) && busy_q[e] && ((pend_q[e] & src_oh) != '0);
    assign pend_left = pend_q[e] & ~src_oh;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[e] <= 1'b0;
        excl_q[e] <= 1'b0;
        pres_q[e] <= '0;
        pend_q[e] <= '0;
        mem_q[e]  <= '0;
      end else if (wr_hit) begin
        busy_q[e] <= wr_busy_i;
        excl_q[e] <= wr_excl_i;
        pres_q[e] <= wr_pres_i;
        pend_q[e] <= wr_pend_i;
      end else if (rsp_hit) begin
        pend_q[e] <= pend_left;
        busy_q[e] <= pend_left != '0;
        if (rsp_rev_i) mem_q[e] <= rsp_data_i;
      end
    end

    p_excl_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      excl_q[e] |-> ($countones(pres_q[e]) == 1));
    p_pend_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q[e] |-> (pend_q[e] != '0));
    p_idle_nopend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q[e] |-> (pend_q[e] == '0));
    p_no_clash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_hit && busy_q[e]));
  end
endmodule

// File: rtl/dir_msg_seq.sv
module dir_msg_seq
  import dir_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [N-1:0]  ld_inv_i,
  input  msg_kind_e     ld_kind_i,
  input  logic [IW-1:0] ld_dst_i,
  input  logic [IW-1:0] ld_req_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  output logic          busy_o,
  output logic          msg_valid_o,
  input  logic          msg_ready_i,
  output msg_kind_e     msg_kind_o,
  output logic [IW-1:0] msg_dst_o,
  output logic [IW-1:0] msg_req_o,
  output logic [AW-1:0] msg_addr_o,
  output logic [DW-1:0] msg_data_o
);
  logic          act_q;
  logic [N-1:0]  inv_q;
  msg_kind_e     kind_q;
  logic [IW-1:0] dst_q;
  logic [IW-1:0] req_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [IW-1:0] inv_idx;
  logic [N-1:0]  inv_oh;
  logic          fire;

  always_comb begin
    inv_idx = '0;
    for (int i = N - 1; i >= 0; i--) if (inv_q[i]) inv_idx = IW'(i);
    inv_oh = '0;
    inv_oh[inv_idx] = 1'b1;
  end

  assign fire        = act_q && msg_ready_i;
  assign busy_o      = act_q;
  assign msg_valid_o = act_q;
  assign msg_req_o   = req_q;
  assign msg_addr_o  = addr_q;

  always_comb begin
    if (inv_q != '0) begin
      msg_kind_o = MSG_INV;
      msg_dst_o  = inv_idx;
      msg_data_o = '0;
    end else begin
      msg_kind_o = kind_q;
      msg_dst_o  = dst_q;
      msg_data_o = (kind_q == MSG_DATA_SHR || kind_q == MSG_DATA_EXCL) ? data_q : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      inv_q  <= '0;
      kind_q <= MSG_NACK;
      dst_q  <= '0;
      req_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      act_q  <= 1'b1;
      inv_q  <= ld_inv_i;
      kind_q <= ld_kind_i;
      dst_q  <= ld_dst_i;
      req_q  <= ld_req_i;
      addr_q <= ld_addr_i;
      data_q <= ld_data_i;
    end else if (fire) begin
      if (inv_q != '0) inv_q <= inv_q & ~inv_oh;
      else             act_q <= 1'b0;
    end
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_kind_o)
      && $stable(msg_dst_o) && $stable(msg_addr_o) && $stable(msg_data_o)));
  p_load_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !act_q);
  p_inv_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && msg_kind_o == MSG_INV) |=> msg_valid_o);
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_ENT  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  parameter int ID_W   = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_PROC-1:0]        req_valid_i,
  input  logic [N_PROC-1:0]        req_excl_i,
  input  logic [N_PROC*ADDR_W-1:0] req_addr_i,
  output logic [N_PROC-1:0]        req_ready_o,
  input  logic                     rsp_valid_i,
  input  logic                     rsp_rev_i,
  input  logic [ID_W-1:0]          rsp_src_i,
  input  logic [ADDR_W-1:0]        rsp_addr_i,
  input  logic [DATA_W-1:0]        rsp_data_i,
  output logic                     rsp_ready_o,
  output logic                     msg_valid_o,
  input  logic                     msg_ready_i,
  output logic [2:0]               msg_kind_o,
  output logic [ID_W-1:0]          msg_dst_o,
  output logic [ID_W-1:0]          msg_req_o,
  output logic [ADDR_W-1:0]        msg_addr_o,
  output logic [DATA_W-1:0]        msg_data_o
);
  logic              seq_busy;
  logic              acc;
  logic [ID_W-1:0]   sel_idx;
  logic [ADDR_W-1:0] sel_addr;
  logic              sel_rdx;
  logic              st_busy, st_excl;
  logic [N_PROC-1:0] st_pres;
  logic [DATA_W-1:0] st_data;
  logic              d_we, d_busy, d_excl;
  logic [N_PROC-1:0] d_pres, d_pend, d_inv;
  msg_kind_e         d_kind;
  logic [ID_W-1:0]   d_dst;
  msg_kind_e         out_kind;

  assign rsp_ready_o = 1'b1;

  dir_prio_arb #(.N(N_PROC), .IW(ID_W)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (!seq_busy),
    .req_i (req_valid_i),
    .gnt_o (req_ready_o),
    .idx_o (sel_idx),
    .any_o (acc)
  );

  assign sel_addr = req_addr_i[sel_idx*ADDR_W +: ADDR_W];
  assign sel_rdx  = req_excl_i[sel_idx];

  dir_store #(.N(N_PROC), .NE(N_ENT), .DW(DATA_W), .AW(ADDR_W), .IW(ID_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (sel_addr),
    .rd_busy_o (st_busy),
    .rd_excl_o (st_excl),
    .rd_pres_o (st_pres),
    .rd_data_o (st_data),
    .wr_en_i   (acc && d_we),
    .wr_addr_i (sel_addr),
    .wr_busy_i (d_busy),
    .wr_excl_i (d_excl),
    .wr_pres_i (d_pres),
    .wr_pend_i (d_pend),
    .rsp_en_i  (rsp_valid_i),
    .rsp_addr_i(rsp_addr_i),
    .rsp_src_i (rsp_src_i),
    .rsp_rev_i (rsp_rev_i),
    .rsp_data_i(rsp_data_i)
  );

  dir_decide #(.N(N_PROC), .IW(ID_W)) u_decide (
    .busy_i  (st_busy),
    .excl_i  (st_excl),
    .pres_i  (st_pres),
    .req_id_i(sel_idx),
    .rdx_i   (sel_rdx),
    .we_o    (d_we),
    .nbusy_o (d_busy),
    .nexcl_o (d_excl),
    .npres_o (d_pres),
    .npend_o (d_pend),
    .kind_o  (d_kind),
    .dst_o   (d_dst),
    .inv_o   (d_inv)
  );

  dir_msg_seq #(.N(N_PROC), .DW(DATA_W), .AW(ADDR_W), .IW(ID_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (acc),
    .ld_inv_i   (d_inv),
    .ld_kind_i  (d_kind),
    .ld_dst_i   (d_dst),
    .ld_req_i   (sel_idx),
    .ld_addr_i  (sel_addr),
    .ld_data_i  (st_data),
    .busy_o     (seq_busy),
    .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i),
    .msg_kind_o (out_kind),
    .msg_dst_o  (msg_dst_o),
    .msg_req_o  (msg_req_o),
    .msg_addr_o (msg_addr_o),
    .msg_data_o (msg_data_o)
  );

  assign msg_kind_o = out_kind;

  p_one_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_busy_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && st_busy) |=> (msg_valid_o && msg_kind_o == 3'd5 && msg_dst_o == msg_req_o));
  p_no_accept_pending_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |-> (req_ready_o == '0));
  p_rsp_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o);
endmodule

// File: tb/dir_home_ctrl_test.sv
`timescale 1ns/1ps
module dir_home_ctrl_test;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [NP-1:0] req_excl = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP-1:0] req_ready;
  logic          rsp_valid = 1'b0;
  logic          rsp_rev = 1'b0;
  logic [IW-1:0] rsp_src = '0;
  logic [AW-1:0] rsp_addr = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          rsp_ready;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [2:0]    msg_kind;
  logic [IW-1:0] msg_dst, msg_req;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0]    kind;
    logic [IW-1:0] dst;
    logic [IW-1:0] rq;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  dir_home_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_excl_i(req_excl), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_i(rsp_valid), .rsp_rev_i(rsp_rev), .rsp_src_i(rsp_src), .rsp_addr_i(rsp_addr),
    .rsp_data_i(rsp_data), .rsp_ready_o(rsp_ready),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_kind_o(msg_kind), .msg_dst_o(msg_dst),
    .msg_req_o(msg_req), .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_msg(input logic [2:0] k, input int d, input int r, input int a,
                            input logic [DW-1:0] dat, input string tag);
    exp_t e;
    e.kind = k; e.dst = IW'(d); e.rq = IW'(r); e.addr = AW'(a); e.data = dat; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare every handshaken message against the scoreboard
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected message", {49'd0, msg_kind, msg_dst, msg_req, msg_addr}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(msg_kind == e.kind && msg_dst == e.dst && msg_req == e.rq &&
            msg_addr == e.addr && msg_data == e.data, e.tag,
            {21'd0, msg_kind, msg_dst, msg_req, msg_addr, msg_data},
            {21'd0, e.kind, e.dst, e.rq, e.addr, e.data});
      end
    end
  end

  task automatic do_req(input int p, input bit rdx, input int a);
    @(posedge clk); #1;
    req_valid[p] = 1'b1;
    req_excl[p]  = rdx;
    req_addr[p*AW +: AW] = AW'(a);
    @(negedge clk);
    while (!req_ready[p]) @(negedge clk);
    @(posedge clk); #1;
    req_valid[p] = 1'b0;
  endtask

  task automatic do_rsp(input int s, input bit rev, input int a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    rsp_valid = 1'b1; rsp_rev = rev; rsp_src = IW'(s); rsp_addr = AW'(a); rsp_data = d;
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R12 watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(msg_valid == 1'b0, "R1 msg_valid after reset", 64'(msg_valid), 64'd0);
    chk(req_ready == '0, "R1 req_ready after reset", 64'(req_ready), 64'd0);
    chk(rsp_ready == 1'b1, "R1 rsp_ready after reset", 64'(rsp_ready), 64'd1);

    // R1: untouched block reads as zero, uncached
    expect_msg(3'd1, 2, 2, 9, 32'h0, "R1 untouched block grant");
    do_req(2, 1'b0, 9);
    drain();

    // R3: read uncached block
    expect_msg(3'd1, 0, 0, 3, 32'h0, "R3 exclusive grant on uncached read");
    do_req(0, 1'b0, 3);
    drain();

    // R11: holder re-requests
    expect_msg(3'd5, 0, 0, 3, 32'h0, "R11 nack to exclusive holder");
    do_req(0, 1'b0, 3);
    drain();

    // R7: read on exclusive block forwards to owner
    expect_msg(3'd4, 0, 1, 3, 32'h0, "R7 forward-read to owner");
    // R8: conflicting request while busy
    expect_msg(3'd5, 2, 2, 3, 32'h0, "R8 nack on busy block");
    do_req(1, 1'b0, 3);
    do_req(2, 1'b0, 3);
    drain();

    // R9: stray response from a port owing nothing is ignored
    do_rsp(3, 1'b0, 3, 32'h0);
    expect_msg(3'd5, 2, 2, 3, 32'h0, "R9 still busy after stray response");
    do_req(2, 1'b0, 3);
    drain();

    // R10: revision writes memory and completes
    do_rsp(0, 1'b1, 3, 32'h1234_5678);
    expect_msg(3'd0, 2, 2, 3, 32'h1234_5678, "R4 shared grant carries revision data R10");
    do_req(2, 1'b0, 3);
    drain();

    // R5 + R12: read-exclusive with two sharers, output stalled
    @(posedge clk); #1 msg_ready = 1'b0;
    expect_msg(3'd2, 0, 1, 3, 32'h0, "R5 invalidate port 0");
    expect_msg(3'd2, 2, 1, 3, 32'h0, "R5 invalidate port 2");
    expect_msg(3'd1, 1, 1, 3, 32'h1234_5678, "R5 exclusive grant after invalidations");
    expect_msg(3'd5, 3, 3, 3, 32'h0, "R8 nack while acks outstanding");
    do_req(1, 1'b1, 3);
    repeat (2) @(negedge clk);
    chk(msg_valid && msg_kind == 3'd2 && msg_dst == 2'd0, "R12 stalled message offered",
        {61'd0, msg_kind}, 64'd2);
    @(posedge clk); #1;
    req_valid[3] = 1'b1; req_excl[3] = 1'b0; req_addr[3*AW +: AW] = 4'd3;
    @(negedge clk);
    chk(req_ready[3] == 1'b0, "R12 no accept while messages pending", 64'(req_ready), 64'd0);
    chk(msg_kind == 3'd2 && msg_dst == 2'd0, "R12 stalled message stable",
        {59'd0, msg_kind, msg_dst}, {59'd0, 3'd2, 2'd0});
    @(posedge clk); #1 msg_ready = 1'b1;
    @(negedge clk);
    while (!req_ready[3]) @(negedge clk);
    @(posedge clk); #1 req_valid[3] = 1'b0;
    drain();
    do_rsp(0, 1'b0, 3, 32'h0);
    expect_msg(3'd5, 3, 3, 3, 32'h0, "R9 busy until last ack");
    do_req(3, 1'b0, 3);
    drain();
    do_rsp(2, 1'b0, 3, 32'h0);

    // R6: read-exclusive on exclusive block
    expect_msg(3'd3, 1, 0, 3, 32'h0, "R6 forward-invalidate to owner");
    do_req(0, 1'b1, 3);
    drain();
    do_rsp(1, 1'b1, 3, 32'hCAFE_0001);
    expect_msg(3'd4, 0, 2, 3, 32'h0, "R6 requester became owner");
    do_req(2, 1'b0, 3);
    drain();
    do_rsp(0, 1'b1, 3, 32'h0BAD_0002);
    expect_msg(3'd0, 3, 3, 3, 32'h0BAD_0002, "R7 block shared after forward R10");
    do_req(3, 1'b0, 3);
    drain();

    // R2: simultaneous requests, lowest port first
    expect_msg(3'd1, 1, 1, 5, 32'h0, "R2 lowest port served first");
    expect_msg(3'd4, 1, 3, 5, 32'h0, "R2 higher port served later");
    @(posedge clk); #1;
    req_valid[1] = 1'b1; req_excl[1] = 1'b0; req_addr[1*AW +: AW] = 4'd5;
    req_valid[3] = 1'b1; req_excl[3] = 1'b0; req_addr[3*AW +: AW] = 4'd5;
    @(negedge clk);
    chk(req_ready == 4'b0010, "R2 only lowest port ready", 64'(req_ready), 64'b0010);
    @(posedge clk); #1 req_valid[1] = 1'b0;
    @(negedge clk);
    while (!req_ready[3]) @(negedge clk);
    @(posedge clk); #1 req_valid[3] = 1'b0;
    drain();
    do_rsp(1, 1'b1, 5, 32'h0000_0055);

    // R5: upgrade with one other sharer
    expect_msg(3'd2, 1, 3, 5, 32'h0, "R5 invalidate other sharer only");
    expect_msg(3'd1, 3, 3, 5, 32'h0000_0055, "R5 upgrade grant");
    do_req(3, 1'b1, 5);
    drain();
    do_rsp(1, 1'b0, 5, 32'h0);

    // R5: no other holder, grant only
    expect_msg(3'd1, 2, 2, 15, 32'h0, "R5 grant without invalidations");
    do_req(2, 1'b1, 15);
    drain();

    chk(exp_q.size() == 0, "R12 scoreboard empty at end", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule